// File: doc/BRIEF.md
# Beverage Recipe Sequencer

This block sequences an automatic coffee and tea dispenser. A 3-bit drink code comes with a one-cycle start strobe. The controller stores the code and then works through that drink's fixed list of dispensing steps. Each step turns on exactly one actuator enable for a number of clock cycles set by a parameter. After the last timed step, the controller gives a one-cycle completion pulse and goes back to idle, where it can take the next order.

Six drinks are built in: plain milk, espresso, cappuccino, americano, tea and lemon tea. Every list starts by placing the cup and ends with a ready-to-serve point. That point is the completion pulse and has no actuator of its own. All timed steps share one down-counter, which is reloaded each time a step is entered. A step that appears twice in a row is held as two separate intervals, so its enable stays high without a break. A parameter mask can take any drink out of the menu. A masked drink code is treated like an unknown code, and the other drinks run as before.

Top module: `bev_dispense_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller goes idle. From the next cycle `act_en` is 0, `busy` is 0 and `done` is 0.
- R2: When `start` is high at an edge while the controller is idle and the code is valid, `busy` goes high in the next cycle and `act_en` equals 8'h01 (cup).
- R3: A start with code 6 or 7 has no effect. The controller stays idle with all outputs low.
- R4: Each bit of `act_en` drives one actuator: bit0 cup, bit1 milk, bit2 coffee powder, bit3 tea leaves, bit4 lemon syrup, bit5 water, bit6 sugar, bit7 stir. The drink codes and their step orders are:
  - 0 milk: cup, milk, sugar, stir.
  - 1 espresso: cup, coffee, water, sugar, stir.
  - 2 cappuccino: cup, coffee, milk, sugar, stir.
  - 3 americano: cup, coffee, water, water, sugar, stir.
  - 4 tea: cup, tea, water, sugar, stir.
  - 5 lemon tea: cup, tea, lemon, water, sugar, stir.
- R5: In the americano, water is dispensed as two back-to-back intervals. Bit5 stays high for exactly 2*WATER_CYC consecutive cycles.
- R6: Each step holds its enable for exactly its parameter's number of cycles. The parameters are CUP_CYC for cup; POUR_CYC for milk, coffee, tea and lemon; WATER_CYC for water; SUGAR_CYC for sugar; and STIR_CYC for stir.
- R7: At most one bit of `act_en` is high at any time. `busy` is high exactly when an enable is high.
- R8: In the cycle after the stir step ends, `done` is high for one cycle with `busy` low. The controller is then idle and can accept a start in the next cycle.
- R9: While a recipe runs, and during the `done` cycle, `start` and `mode_sel` are ignored.
- R10: A drink whose bit in RECIPE_EN is 0 acts as an invalid code. The enabled drinks are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Order strobe, sampled only when idle |
| mode_sel | input | 3 | Drink code, stored with the strobe |
| act_en | output | 8 | One-hot actuator enables |
| busy | output | 1 | A recipe step is active |
| done | output | 1 | One-cycle ready-to-serve pulse |

## Verification
The hardest case to reach is an order that lands on the exact boundary between runs. One such case is a strobe in the completion cycle, which must be dropped. The other is a strobe in the first idle cycle after it, which must be accepted. The stimulus times these strobes from the observed `done` pulse. It also fires extra strobes with changing codes during the americano's double water step, so that a stray reload would show up as a broken or lengthened water interval. A second instance with one drink masked out shows that masking leaves the other drinks running.

// File: rtl/bev_pkg.sv
package bev_pkg;

    localparam int unsigned NUM_ACT    = 8;
    localparam int unsigned NUM_DRINKS = 6;
    localparam int unsigned STEP_W     = 3;
    localparam int unsigned MODE_W     = 3;

    typedef enum logic [2:0] {
        DR_MILK      = 3'd0,
        DR_ESPRESSO  = 3'd1,
        DR_CAPPU     = 3'd2,
        DR_AMERICANO = 3'd3,
        DR_TEA       = 3'd4,
        DR_LEMON_TEA = 3'd5
    } drink_e;

    // value of each timed stage equals its enable bit position
    typedef enum logic [3:0] {
        SG_CUP    = 4'd0,
        SG_MILK   = 4'd1,
        SG_COFFEE = 4'd2,
        SG_TEA    = 4'd3,
        SG_LEMON  = 4'd4,
        SG_WATER  = 4'd5,
        SG_SUGAR  = 4'd6,
        SG_STIR   = 4'd7,
        SG_FINISH = 4'd8
    } stage_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    function automatic logic [NUM_ACT-1:0] stage_onehot(stage_e s);
        logic [NUM_ACT-1:0] v;
        v = '0;
        if (s != SG_FINISH) v[s[2:0]] = 1'b1;
        return v;
    endfunction

    function automatic stage_e recipe_step(drink_e d, logic [STEP_W-1:0] i);
        stage_e s;
        s = SG_FINISH;
        case (d)
            DR_MILK: case (i)
                3'd0: s = SG_CUP;    3'd1: s = SG_MILK;
                3'd2: s = SG_SUGAR;  3'd3: s = SG_STIR;
                default: s = SG_FINISH;
            endcase
            DR_ESPRESSO: case (i)
                3'd0: s = SG_CUP;    3'd1: s = SG_COFFEE;
                3'd2: s = SG_WATER;  3'd3: s = SG_SUGAR;
                3'd4: s = SG_STIR;
                default: s = SG_FINISH;
            endcase
            DR_CAPPU: case (i)
                3'd0: s = SG_CUP;    3'd1: s = SG_COFFEE;
                3'd2: s = SG_MILK;   3'd3: s = SG_SUGAR;
                3'd4: s = SG_STIR;
                default: s = SG_FINISH;
            endcase
            DR_AMERICANO: case (i)
                3'd0: s = SG_CUP;    3'd1: s = SG_COFFEE;
                3'd2: s = SG_WATER;  3'd3: s = SG_WATER;
                3'd4: s = SG_SUGAR;  3'd5: s = SG_STIR;
                default: s = SG_FINISH;
            endcase
            DR_TEA: case (i)
                3'd0: s = SG_CUP;    3'd1: s = SG_TEA;
                3'd2: s = SG_WATER;  3'd3: s = SG_SUGAR;
                3'd4: s = SG_STIR;
                default: s = SG_FINISH;
            endcase
            DR_LEMON_TEA: case (i)
                3'd0: s = SG_CUP;    3'd1: s = SG_TEA;
                3'd2: s = SG_LEMON;  3'd3: s = SG_WATER;
                3'd4: s = SG_SUGAR;  3'd5: s = SG_STIR;
                default: s = SG_FINISH;
            endcase
            default: s = SG_FINISH;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bev_recipe_rom.sv
module bev_recipe_rom
    import bev_pkg::*;
#(
    parameter logic [NUM_DRINKS-1:0] RECIPE_EN = '1
) (
    input  drink_e              drink,
    input  logic [STEP_W-1:0]   step,
    output stage_e              stage
);
    localparam int unsigned TBL_N = 1 << MODE_W;

    stage_e tbl [TBL_N];

    genvar g;
    generate
        for (g = 0; g < TBL_N; g++) begin : g_drink
            if (g < NUM_DRINKS) begin : g_real
                if (RECIPE_EN[g]) begin : g_on
                    assign tbl[g] = recipe_step(drink_e'(g), step);
                end else begin : g_off
                    assign tbl[g] = SG_FINISH;
                end
            end else begin : g_none
                assign tbl[g] = SG_FINISH;
            end
        end
    endgenerate

    assign stage = tbl[drink];
endmodule

// File: rtl/bev_stage_timer.sv
module bev_stage_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst)                count <= '0;
        else if (load)          count <= load_val;
        else if (count != '0)   count <= count - 1'b1;
    end

    assign expired = (count == '0);

    // R6
    hold_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && count != '0) |=> (count != '1));
endmodule

// File: rtl/bev_seq_fsm.sv
module bev_seq_fsm
    import bev_pkg::*;
#(
    parameter int unsigned CUP_CYC   = 3,
    parameter int unsigned POUR_CYC  = 4,
    parameter int unsigned WATER_CYC = 5,
    parameter int unsigned SUGAR_CYC = 2,
    parameter int unsigned STIR_CYC  = 6,
    parameter int unsigned CNT_W     = 3,
    parameter logic [NUM_DRINKS-1:0] RECIPE_EN = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              expired,
    input  stage_e            next_stage,
    output phase_e            phase,
    output drink_e            drink_q,
    output logic [STEP_W-1:0] step_q,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val
);
    localparam int unsigned EN_W = 1 << MODE_W;
    localparam logic [EN_W-1:0] EN_EXT = EN_W'(RECIPE_EN);

    function automatic logic [CNT_W-1:0] dur_of(stage_e s);
        int unsigned c;
        case (s)
            SG_CUP:                          c = CUP_CYC;
            SG_MILK, SG_COFFEE,
            SG_TEA, SG_LEMON:                c = POUR_CYC;
            SG_WATER:                        c = WATER_CYC;
            SG_SUGAR:                        c = SUGAR_CYC;
            SG_STIR:                         c = STIR_CYC;
            default:                         c = 1;
        endcase
        return CNT_W'(c - 1);
    endfunction

    logic mode_ok;
    logic accept;
    logic advance;
    logic last_step;

    assign mode_ok   = (mode_sel < MODE_W'(NUM_DRINKS)) && EN_EXT[mode_sel];
    assign accept    = (phase == PH_IDLE) && start && mode_ok;
    assign advance   = (phase == PH_RUN) && expired;
    assign last_step = (next_stage == SG_FINISH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            drink_q <= DR_MILK;
            step_q  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase   <= PH_RUN;
                    drink_q <= drink_e'(mode_sel);
                    step_q  <= '0;
                end
                PH_RUN: if (advance) begin
                    if (last_step) phase  <= PH_DONE;
                    else           step_q <= step_q + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign tmr_load = accept || (advance && !last_step);
    assign tmr_val  = (phase == PH_IDLE) ? dur_of(SG_CUP) : dur_of(next_stage);

    // R3
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start && mode_sel >= 3'd6) |=> (phase == PH_IDLE));

    // R9
    order_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN && !expired) |=> ($stable(drink_q) && $stable(step_q)));
endmodule

// File: rtl/bev_dispense_ctrl.sv
module bev_dispense_ctrl
    import bev_pkg::*;
#(
    parameter int unsigned CUP_CYC   = 3,
    parameter int unsigned POUR_CYC  = 4,
    parameter int unsigned WATER_CYC = 5,
    parameter int unsigned SUGAR_CYC = 2,
    parameter int unsigned STIR_CYC  = 6,
    parameter logic [5:0]  RECIPE_EN = 6'b111111
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] mode_sel,
    output logic [7:0] act_en,
    output logic       busy,
    output logic       done
);
    localparam int unsigned M1 = (CUP_CYC > POUR_CYC) ? CUP_CYC : POUR_CYC;
    localparam int unsigned M2 = (M1 > WATER_CYC) ? M1 : WATER_CYC;
    localparam int unsigned M3 = (M2 > SUGAR_CYC) ? M2 : SUGAR_CYC;
    localparam int unsigned MAX_CYC = (M3 > STIR_CYC) ? M3 : STIR_CYC;
    localparam int unsigned CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    phase_e              phase;
    drink_e              drink_q;
    logic [STEP_W-1:0]   step_q;
    logic [STEP_W-1:0]   step_nx;
    stage_e              cur_stage;
    stage_e              next_stage;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                expired;

    assign step_nx = step_q + 1'b1;

    bev_recipe_rom #(.RECIPE_EN(RECIPE_EN)) i_rom_cur (
        .drink(drink_q), .step(step_q),  .stage(cur_stage));
    bev_recipe_rom #(.RECIPE_EN(RECIPE_EN)) i_rom_nxt (
        .drink(drink_q), .step(step_nx), .stage(next_stage));

    bev_seq_fsm #(
        .CUP_CYC(CUP_CYC), .POUR_CYC(POUR_CYC), .WATER_CYC(WATER_CYC),
        .SUGAR_CYC(SUGAR_CYC), .STIR_CYC(STIR_CYC), .CNT_W(CNT_W),
        .RECIPE_EN(RECIPE_EN)
    ) i_fsm (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .expired(expired), .next_stage(next_stage), .phase(phase),
        .drink_q(drink_q), .step_q(step_q), .tmr_load(tmr_load),
        .tmr_val(tmr_val));

    bev_stage_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .expired(expired));

    assign act_en = (phase == PH_RUN) ? stage_onehot(cur_stage) : '0;
    assign busy   = (phase == PH_RUN);
    assign done   = (phase == PH_DONE);

    // R7
    single_act_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_en));

    // R7
    busy_match_chk: assert property (@(posedge clk) disable iff (rst)
        busy == (act_en != 8'h00));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R2
    first_cup_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start && mode_sel < 3'd6 && RECIPE_EN[mode_sel])
        |=> (busy && act_en == 8'h01));
endmodule

// File: tb/test_bev_dispense_ctrl.sv
module test_bev_dispense_ctrl;
    localparam int CUP = 3, POUR = 4, WAT = 5, SUG = 2, STR = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [2:0] mode_sel;
    logic [7:0] act_en, act_m;
    logic       busy, done, busy_m, done_m;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int wrun  = 0;
    int wmax  = 0;
    int bcnt  = 0;
    logic [9:0] exp_q[$];

    always #5 clk = ~clk;

    bev_dispense_ctrl #(.CUP_CYC(CUP), .POUR_CYC(POUR), .WATER_CYC(WAT),
        .SUGAR_CYC(SUG), .STIR_CYC(STR)) i_bev_dispense_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .act_en(act_en), .busy(busy), .done(done));

    // tea (code 4) masked out
    bev_dispense_ctrl #(.CUP_CYC(CUP), .POUR_CYC(POUR), .WATER_CYC(WAT),
        .SUGAR_CYC(SUG), .STIR_CYC(STR), .RECIPE_EN(6'b101111)) i_bev_dispense_ctrl_m (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .act_en(act_m), .busy(busy_m), .done(done_m));

    function automatic int dur_of_bit(int b);
        if (b == 0) return CUP;
        if (b == 5) return WAT;
        if (b == 6) return SUG;
        if (b == 7) return STR;
        return POUR;
    endfunction

    function automatic void push_recipe(int m);
        int seq[$];
        case (m)
            0: seq = '{0, 1, 6, 7};
            1: seq = '{0, 2, 5, 6, 7};
            2: seq = '{0, 2, 1, 6, 7};
            3: seq = '{0, 2, 5, 5, 6, 7};
            4: seq = '{0, 3, 5, 6, 7};
            default: seq = '{0, 3, 4, 5, 6, 7};
        endcase
        foreach (seq[k]) begin
            for (int n = 0; n < dur_of_bit(seq[k]); n++)
                exp_q.push_back({1'b0, 1'b1, 8'(1 << seq[k])});
        end
        exp_q.push_back({1'b1, 1'b0, 8'h00});
    endfunction

    // behavioural reference: queue of expected per-cycle outputs
    always @(posedge clk) begin
        if (rst) exp_q.delete();
        else begin
            automatic bit idle = (exp_q.size() == 0);
            if (!idle) void'(exp_q.pop_front());
            if (idle && start && mode_sel < 3'd6) push_recipe(int'(mode_sel));
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    // per-cycle compare, away from the active edge
    always @(negedge clk) begin
        automatic logic [9:0] e = (exp_q.size() != 0) ? exp_q[0] : 10'h0;
        automatic string tag;
        if (rst) tag = "R1";
        else if (e[9]) tag = "R8";
        else if (e == 10'h0) tag = "R3 R9";
        else tag = "R4 R6";
        check(tag, {22'h0, done, busy, act_en}, {22'h0, e});
        check("R7", 32'($countones(act_en) <= 1), 32'd1);
        if (act_en[5]) begin
            wrun++;
            if (wrun > wmax) wmax = wrun;
        end else wrun = 0;
        if (busy) bcnt++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic pulse(int m);
        @(negedge clk);
        start    = 1'b1;
        mode_sel = 3'(m);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (45) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode_sel = 3'd0;
        repeat (3) @(negedge clk);
        check("R1", {act_en, busy, done}, 10'h0);
        rst = 1'b0;

        for (int m = 0; m < 8; m++) begin
            pulse(m);
            #1;
            if (m < 6) check("R2", {24'h0, act_en}, 32'h01);
            else       check("R3", {30'h0, busy, done}, 32'h0);
            wait_idle();
        end

        // americano with disturbance during the double water step
        wmax = 0; bcnt = 0;
        pulse(3);
        repeat (8) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            start = k[0];
            mode_sel = 3'(k);
            @(negedge clk);
        end
        start = 1'b0;
        wait_idle();
        check("R5", wmax, 2 * WAT);
        check("R9", bcnt, CUP + POUR + 2 * WAT + SUG + STR);

        // start in the done cycle (dropped), then right after (taken)
        pulse(0);
        @(posedge done);
        @(negedge clk);
        start = 1'b1; mode_sel = 3'd1;
        @(negedge clk);
        check("R9", {30'h0, busy, done}, 32'h0);
        mode_sel = 3'd2;
        @(negedge clk);
        start = 1'b0;
        check("R8", {24'h0, act_en}, 32'h01);
        wait_idle();

        // reset during a run
        pulse(5);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", {act_en, busy, done}, 10'h0);
        wait_idle();

        // masked drink on the second instance
        pulse(4);
        repeat (3) @(negedge clk);
        check("R10", {act_m, busy_m, done_m}, 10'h0);
        wait_idle();
        pulse(0);
        #1;
        check("R10", {act_m, busy_m}, {8'h01, 1'b1});
        wait_idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule